// File: doc/BRIEF.md
# Memory access cycle estimator

This block estimates the processor cycles spent on one memory access and folds stage costs into per-instruction totals for a two-core system. One core is fast, with a five-stage pipeline; the other is slow, with a three-stage pipeline. For each access the caller presents the address, width, kind (code, data, DMA), direction and a sequential flag. It also presents which core is issuing the access, whether detailed timing is on, and a cache-hit verdict from an external tag predictor. The block returns the cost in cycles.

In the same cycle the caller supplies ALU, memory and fetch cycle counts. The block returns the execute cost and the combined fetch-plus-execute cost. All results are registered and appear one clock after the inputs are sampled. Cycle counts are `CW` bits wide and saturate at the all-ones value instead of wrapping. Before any decode, the address is aligned down to the access width.

Top module: `mem_cycle_est`

## Requirements
- R1: While rst_ni is low, all three outputs read 0.
- R2: On the fast core (core_sel_i=0), a code access (kind_i=0) to an address below 0x0200_0000 costs 1 cycle.
- R3: On the fast core, with timing_en_i=1 and kind_i of 0 or 1, an address whose bits 27:24 equal 4'h2 is cached, and a hit (cache_hit_i=1) costs 1 cycle.
- R4: A write miss in the cached region costs M16 when sequential data (seq_i=1, kind_i=1), and otherwise 2×M16. Here M32 is 2 on the fast core and 1 on the slow core. M16 is 2×M32 for word accesses (size_i 2 or 3) and M32 for byte (0) or halfword (1) accesses.
- R5: A read miss (write_i=0) in the cached region costs a base plus a line fill of 16×M32. The base is M16 for sequential data and 5×M16 otherwise.
- R6: Any other access costs M16 when timing is off or the access is sequential. DMA is kind_i 2 or 3.
- R7: With timing on, a non-sequential access outside the paths of R2 and R3 adds 6 cycles on the fast core and 1 cycle on the slow core.
- R8: On the fast core, the execute cost is max(alu_cyc_i, mem_cyc_i).
- R9: On the slow core, the execute cost is alu_cyc_i + mem_cyc_i, saturating at 255.
- R10: The fetch-execute cost is max(execute, fetch_cyc_i) with timing on, and the execute cost alone with timing off.
- R11: Each output reflects the inputs sampled at the previous rising clock edge and holds until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 32 | Byte address of the access |
| size_i | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| kind_i | input | 2 | 0 code, 1 data, 2 or 3 DMA |
| write_i | input | 1 | 1 write, 0 read |
| seq_i | input | 1 | Access is sequential to the previous one |
| core_sel_i | input | 1 | 0 fast core, 1 slow core |
| timing_en_i | input | 1 | Detailed timing enabled |
| cache_hit_i | input | 1 | Predictor hit verdict for the cached region |
| alu_cyc_i | input | 8 | ALU stage cycles |
| mem_cyc_i | input | 8 | Memory stage cycles |
| fetch_cyc_i | input | 8 | Fetch stage cycles |
| acc_cyc_o | output | 8 | Cost of the presented access |
| exec_cyc_o | output | 8 | Execute cost |
| fe_cyc_o | output | 8 | Fetch-plus-execute cost |

## Verification
The only state is the output register stage. A wrong decode or an arithmetic slip therefore shows up as a wrong count on the very next clock and affects only that one vector. The bench sweeps every combination of core, kind, width, direction, sequential flag, timing and hit over addresses on both sides of every region edge. It also sweeps the stage combiner over small, mid-range and saturating values, so a bad branch or a wrapped sum is caught within one cycle of its first trigger.

// File: rtl/mce_pkg.sv
package mce_pkg;
  localparam logic [1:0] KIND_CODE = 2'd0;
  localparam logic [1:0] KIND_DATA = 2'd1;
  localparam logic [1:0] SIZE_HALF = 2'd1;
  localparam logic       CORE_FAST = 1'b0;
endpackage

// File: rtl/mce_align.sv
module mce_align #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  output logic [AW-1:0] addr_o
);
  always_comb begin
    addr_o = addr_i;
    if (size_i >= mce_pkg::SIZE_HALF) addr_o[0] = 1'b0;
    if (size_i[1])                    addr_o[1] = 1'b0;
  end
endmodule

// File: rtl/mce_access_lat.sv
module mce_access_lat #(
  parameter int          AW          = 32,
  parameter int          CW          = 8,
  parameter logic [31:0] TCM_LIMIT   = 32'h0200_0000,
  parameter logic [3:0]  CACHED_NIB  = 4'h2,
  parameter int          FILL_BEATS  = 8,
  parameter int          FAST_NS_PEN = 6,
  parameter int          SLOW_NS_PEN = 1
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic [1:0]    kind_i,
  input  logic          write_i,
  input  logic          seq_i,
  input  logic          slow_i,
  input  logic          timing_i,
  input  logic          hit_i,
  output logic [CW-1:0] cyc_o
);
  import mce_pkg::*;
  localparam int IW = CW + 4;
  localparam logic [IW-1:0] CMAX = IW'((1 << CW) - 1);

  logic [IW-1:0] m32, m16, base, fill, raw;
  logic tcm_hit, cached;

  always_comb begin
    m32 = slow_i ? IW'(1) : IW'(2);
    m16 = size_i[1] ? (m32 << 1) : m32;
    tcm_hit = !slow_i && (kind_i == KIND_CODE) && (addr_i < AW'(TCM_LIMIT));
    cached  = !slow_i && !kind_i[1] && timing_i && (addr_i[27:24] == CACHED_NIB);

    if (seq_i && kind_i == KIND_DATA) base = m16;
    else if (!write_i)                base = (m16 << 2) + m16;
    else                              base = m16 << 1;
    fill = write_i ? '0 : IW'(FILL_BEATS * 2) * m32;

    if (tcm_hit)                      raw = IW'(1);
    else if (cached && hit_i)         raw = IW'(1);
    else if (cached)                  raw = base + fill;
    else if (timing_i && !seq_i)      raw = m16 + (slow_i ? IW'(SLOW_NS_PEN) : IW'(FAST_NS_PEN));
    else                              raw = m16;

    cyc_o = (raw > CMAX) ? CMAX[CW-1:0] : raw[CW-1:0];
  end
endmodule

// File: rtl/mce_stage_comb.sv
module mce_stage_comb #(
  parameter int CW = 8
) (
  input  logic          slow_i,
  input  logic          timing_i,
  input  logic [CW-1:0] alu_i,
  input  logic [CW-1:0] mem_i,
  input  logic [CW-1:0] fetch_i,
  output logic [CW-1:0] exec_o,
  output logic [CW-1:0] fe_o
);
  logic [CW:0] sum;
  always_comb begin
    sum = {1'b0, alu_i} + {1'b0, mem_i};
    if (slow_i) exec_o = sum[CW] ? '1 : sum[CW-1:0];
    else        exec_o = (alu_i > mem_i) ? alu_i : mem_i;
    fe_o = (timing_i && fetch_i > exec_o) ? fetch_i : exec_o;
  end
endmodule

// File: rtl/mem_cycle_est.sv
module mem_cycle_est #(
  parameter int AW = 32,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic [1:0]    kind_i,
  input  logic          write_i,
  input  logic          seq_i,
  input  logic          core_sel_i,
  input  logic          timing_en_i,
  input  logic          cache_hit_i,
  input  logic [CW-1:0] alu_cyc_i,
  input  logic [CW-1:0] mem_cyc_i,
  input  logic [CW-1:0] fetch_cyc_i,
  output logic [CW-1:0] acc_cyc_o,
  output logic [CW-1:0] exec_cyc_o,
  output logic [CW-1:0] fe_cyc_o
);
  logic [AW-1:0] addr_al;
  logic [CW-1:0] acc_d, exec_d, fe_d;

  mce_align #(.AW(AW)) u_align (
    .addr_i(addr_i), .size_i(size_i), .addr_o(addr_al)
  );

  mce_access_lat #(.AW(AW), .CW(CW)) u_lat (
    .addr_i(addr_al), .size_i(size_i), .kind_i(kind_i), .write_i(write_i),
    .seq_i(seq_i), .slow_i(core_sel_i), .timing_i(timing_en_i),
    .hit_i(cache_hit_i), .cyc_o(acc_d)
  );

  mce_stage_comb #(.CW(CW)) u_comb (
    .slow_i(core_sel_i), .timing_i(timing_en_i), .alu_i(alu_cyc_i),
    .mem_i(mem_cyc_i), .fetch_i(fetch_cyc_i), .exec_o(exec_d), .fe_o(fe_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_cyc_o  <= '0;
      exec_cyc_o <= '0;
      fe_cyc_o   <= '0;
    end else begin
      acc_cyc_o  <= acc_d;
      exec_cyc_o <= exec_d;
      fe_cyc_o   <= fe_d;
    end
  end
endmodule

// File: rtl/mem_cycle_est_chk.sv
module mem_cycle_est_chk #(
  parameter int AW = 32,
  parameter int CW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic [1:0]    kind_i,
  input logic          core_sel_i,
  input logic          timing_en_i,
  input logic          cache_hit_i,
  input logic [CW-1:0] alu_cyc_i,
  input logic [CW-1:0] mem_cyc_i,
  input logic [CW-1:0] acc_cyc_o,
  input logic [CW-1:0] exec_cyc_o,
  input logic [CW-1:0] fe_cyc_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;

  assert_reset_zero_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (acc_cyc_o == '0 && exec_cyc_o == '0 && fe_cyc_o == '0));

  assert_tcm_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(!core_sel_i && kind_i == 2'd0 && addr_i < 32'h0200_0000)
      |-> acc_cyc_o == CW'(1));

  assert_hit_one_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(!core_sel_i && !kind_i[1] && timing_en_i && cache_hit_i &&
                     addr_i[27:24] == 4'h2) |-> acc_cyc_o == CW'(1));

  assert_fast_max_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(!core_sel_i) |->
      (exec_cyc_o >= $past(alu_cyc_i) && exec_cyc_o >= $past(mem_cyc_i) &&
       (exec_cyc_o == $past(alu_cyc_i) || exec_cyc_o == $past(mem_cyc_i))));

  assert_no_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(core_sel_i) |->
      (exec_cyc_o >= $past(alu_cyc_i) && exec_cyc_o >= $past(mem_cyc_i)));

  assert_fe_floor_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fe_cyc_o >= exec_cyc_o);
endmodule

bind mem_cycle_est mem_cycle_est_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .kind_i(kind_i),
  .core_sel_i(core_sel_i), .timing_en_i(timing_en_i), .cache_hit_i(cache_hit_i),
  .alu_cyc_i(alu_cyc_i), .mem_cyc_i(mem_cyc_i), .acc_cyc_o(acc_cyc_o),
  .exec_cyc_o(exec_cyc_o), .fe_cyc_o(fe_cyc_o)
);

// File: tb/mem_cycle_est_tb.sv
module mem_cycle_est_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] addr_i = '0;
  logic [1:0]  size_i = '0, kind_i = '0;
  logic        write_i = 0, seq_i = 0, core_sel_i = 0, timing_en_i = 0, cache_hit_i = 0;
  logic [7:0]  alu_cyc_i = '0, mem_cyc_i = '0, fetch_cyc_i = '0;
  logic [7:0]  acc_cyc_o, exec_cyc_o, fe_cyc_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  mem_cycle_est u_dut (.*);

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_acc(logic [31:0] a, int sz, int kd, bit wr, bit sq,
                                 bit slow, bit tm, bit ht, output string tag);
    int m32 = slow ? 1 : 2;
    int m16 = m32 * ((sz >= 2) ? 2 : 1);
    if (!slow && kd == 0 && a < 32'h0200_0000) begin tag = "R2"; return 1; end
    if (!slow && kd < 2 && tm && a[27:24] == 4'h2) begin
      if (ht) begin tag = "R3"; return 1; end
      if (!wr) begin tag = "R5"; return ((sq && kd == 1) ? m16 : 5 * m16) + 16 * m32; end
      tag = "R4"; return (sq && kd == 1) ? m16 : 2 * m16;
    end
    if (tm && !sq) begin tag = "R7"; return m16 + (slow ? 1 : 6); end
    tag = "R6"; return m16;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    logic [31:0] addrs [8] = '{32'h0000_0010, 32'h01FF_FFFE, 32'h0200_0000, 32'h0200_0003,
                               32'h023F_FFFC, 32'h1200_0040, 32'h0300_0000, 32'h0400_0001};
    int vals [7] = '{0, 1, 7, 100, 128, 200, 255};
    int exp_acc, exp_ex, exp_fe;
    string tag;
    alu_cyc_i = 8'd9; mem_cyc_i = 8'd5; fetch_cyc_i = 8'd3; addr_i = 32'h0300_0000;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R1", acc_cyc_o, 0); chk("R1", exec_cyc_o, 0); chk("R1", fe_cyc_o, 0);
    rst_ni = 1'b1;

    // access cost sweep (R2..R7)
    alu_cyc_i = 8'd0; mem_cyc_i = 8'd0; fetch_cyc_i = 8'd0;
    for (int c = 0; c < 2; c++)
      for (int k = 0; k < 4; k++)
        for (int s = 0; s < 4; s++)
          for (int w = 0; w < 2; w++)
            for (int q = 0; q < 2; q++)
              for (int t = 0; t < 2; t++)
                for (int h = 0; h < 2; h++)
                  for (int ai = 0; ai < 8; ai++) begin
                    addr_i = addrs[ai]; size_i = 2'(s); kind_i = 2'(k);
                    write_i = w[0]; seq_i = q[0]; core_sel_i = c[0];
                    timing_en_i = t[0]; cache_hit_i = h[0];
                    exp_acc = ref_acc(addrs[ai], s, k, w[0], q[0], c[0], t[0], h[0], tag);
                    @(posedge clk_i); @(negedge clk_i);
                    chk(tag, acc_cyc_o, exp_acc);
                  end

    // stage combiner sweep (R8, R9, R10)
    addr_i = 32'h0300_0000; kind_i = 2'd1; size_i = 2'd2; seq_i = 1'b1;
    for (int c = 0; c < 2; c++)
      for (int t = 0; t < 2; t++)
        for (int i = 0; i < 7; i++)
          for (int j = 0; j < 7; j++)
            for (int f = 0; f < 7; f++) begin
              core_sel_i = c[0]; timing_en_i = t[0];
              alu_cyc_i = 8'(vals[i]); mem_cyc_i = 8'(vals[j]); fetch_cyc_i = 8'(vals[f]);
              if (c == 0) exp_ex = (vals[i] > vals[j]) ? vals[i] : vals[j];
              else        exp_ex = (vals[i] + vals[j] > 255) ? 255 : vals[i] + vals[j];
              exp_fe = (t == 1 && vals[f] > exp_ex) ? vals[f] : exp_ex;
              @(posedge clk_i); @(negedge clk_i);
              chk(c == 0 ? "R8" : "R9", exec_cyc_o, exp_ex);
              chk("R10", fe_cyc_o, exp_fe);
            end

    // R11: output holds until the next edge after inputs change
    core_sel_i = 1'b1; timing_en_i = 1'b0; alu_cyc_i = 8'd3; mem_cyc_i = 8'd4;
    @(posedge clk_i); @(negedge clk_i);
    alu_cyc_i = 8'd20; mem_cyc_i = 8'd30;
    #1 chk("R11", exec_cyc_o, 7);
    @(posedge clk_i); #1 chk("R11", exec_cyc_o, 50);

    // R1: asynchronous reset clears outputs mid-stream
    @(negedge clk_i); rst_ni = 1'b0; #1;
    chk("R1", exec_cyc_o, 0); chk("R1", acc_cyc_o, 0);
    done = 1;
    summary();
  end
endmodule